// File: doc/BRIEF.md
# Cell and Packet Word FIFO with Overflow Abort

This block is a synchronous first-in first-out store placed between a line-side processor that writes words and a system-side reader. Each word is 32 data bits tagged with a start marker, an end marker and an error tag. A mode input chooses between fixed-size cell traffic, where every word is simply queued, and variable-length packet traffic, where the block follows packet boundaries and a short packet is a word carrying both markers.

When the store is full, the block rejects the incoming word and records an overflow. In packet mode, an overflow in the middle of a packet aborts that packet. The last word already stored for it is retagged with an error and an end marker, and the remaining input words of the packet are discarded up to and including its end marker. A read request while the store is empty is an underflow. Both events set sticky status bits, and each bit clears only on its own write-1-to-clear pulse.

A three-state write controller tracks packet context. WS_IDLE means outside a packet. WS_BODY means inside a stored packet. WS_DROP means discarding an aborted packet. The transitions are:
- WS_IDLE to WS_BODY on an accepted start word without an end marker.
- WS_BODY to WS_IDLE on any end-marked word.
- WS_BODY to WS_DROP on a word without an end marker that meets a full store.
- WS_DROP to WS_IDLE on an end-marked word.
- Cell mode forces WS_IDLE.

Top module: `cpkt_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, rd_valid is 0, and both sticky flags are 0.
- R2: A read request while the store is not empty gives rd_valid in the next cycle. rd_data and the three tags then show the oldest stored word, and words leave in the order they were written.
- R3: full rises after DEPTH (default 8) words are stored without reads. empty rises when every stored word has been read. full and empty are never both 1.
- R4: In cell mode (pkt_mode=0), a write while full sets ovf_flag and is discarded. The stored words and their order are unchanged.
- R5: In packet mode (pkt_mode=1), outside a packet, a start word (wr_sop=1) or a short packet (wr_sop=1 and wr_eop=1) that arrives while full sets ovf_flag and is discarded.
- R6: In packet mode, outside a packet, a word with wr_sop=0 is discarded without any flag.
- R7: In packet mode, a write inside a packet while full sets ovf_flag. The last stored word of that packet then reads out with rd_eop=1 and rd_err=1, and its data is unchanged.
- R8: After an abort, incoming words are discarded up to and including the next end-marked word. The next start word is stored normally with rd_err=0.
- R9: A read request while empty gives rd_valid=0 in the next cycle, sets unf_flag and leaves the read position unchanged. A later write is therefore the next word read.
- R10: Each sticky flag holds until a pulse on its own clear input. Clearing one flag leaves the other unchanged. A set and a clear of the same flag in one cycle leave it set.
- R11: In cell mode the start marker does not govern admission. Words with wr_sop=0 are stored while space remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_mode | input | 1 | 1 selects packet handling, 0 selects cell handling |
| wr_en | input | 1 | Write request from the line-side processor |
| wr_data | input | 32 | Word data |
| wr_sop | input | 1 | Start-of-packet marker of the written word |
| wr_eop | input | 1 | End-of-packet marker of the written word |
| rd_en | input | 1 | Read request from the reader |
| rd_valid | output | 1 | A word was read in the previous cycle |
| rd_data | output | 32 | Data of the word read |
| rd_sop | output | 1 | Start marker of the word read |
| rd_eop | output | 1 | End marker of the word read |
| rd_err | output | 1 | Error tag of the word read (abort) |
| full | output | 1 | Store holds DEPTH words |
| empty | output | 1 | Store holds no word |
| clr_ovf | input | 1 | Write-1-to-clear pulse for ovf_flag |
| clr_unf | input | 1 | Write-1-to-clear pulse for unf_flag |
| ovf_flag | output | 1 | Sticky overflow status |
| unf_flag | output | 1 | Sticky underflow status |

## Verification
The event that sets a sticky flag and the software pulse that clears it can land on the same clock edge. The bench provokes this by holding the store full, then driving a write and clr_ovf in one cycle. It judges the result by ovf_flag reading 1 after that edge, and then 0 after a lone clear pulse. A second collision also arises in one cycle: a read request on an empty store alongside a write. The bench expects the read to be refused and the underflow recorded, while the write is kept and returned by the following read.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    localparam int unsigned CPF_DW = 32;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic              err;
        logic [CPF_DW-1:0] data;
    } word_t;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_BODY = 2'd1,
        WS_DROP = 2'd2
    } wr_state_e;

endpackage

// File: rtl/cpf_store.sv
module cpf_store
    import cpf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_req,
    input  word_t wr_word,
    input  logic  patch_req,
    input  logic  rd_req,
    output logic  full,
    output logic  empty,
    output logic  rd_valid,
    output word_t rd_word
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW:0]   PTR_ONE = {{AW{1'b0}}, 1'b1};
    localparam logic [AW-1:0] IDX_ONE = {{(AW-1){1'b0}}, 1'b1};

    word_t         mem [DEPTH];
    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;
    logic [AW-1:0] last_idx;
    logic          do_wr;
    logic          do_rd;

    // Extra wrap bit distinguishes full from empty when the indices match
    assign empty    = (wr_ptr == rd_ptr);
    assign full     = (wr_ptr[AW] != rd_ptr[AW]) &&
                      (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign do_wr    = wr_req && !full;
    assign do_rd    = rd_req && !empty;
    assign last_idx = wr_ptr[AW-1:0] - IDX_ONE;

    // Storage: a normal write and an abort retag never coincide (retag only when full)
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr[AW-1:0]] <= wr_word;
        end else if (patch_req && !empty) begin
            mem[last_idx].err <= 1'b1;
            mem[last_idx].eop <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + PTR_ONE;
            if (do_rd) rd_ptr <= rd_ptr + PTR_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= do_rd;
            if (do_rd) rd_word <= mem[rd_ptr[AW-1:0]];
        end
    end

endmodule

// File: rtl/cpf_wr_fsm.sv
module cpf_wr_fsm
    import cpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_mode,
    input  logic wr_en,
    input  logic wr_sop,
    input  logic wr_eop,
    input  logic full,
    output logic wr_req,
    output logic patch_req,
    output logic ovf_evt
);

    wr_state_e st;
    wr_state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= WS_IDLE;
        else        st <= nxt;
    end

    // Next state
    always_comb begin
        nxt = st;
        if (!pkt_mode) begin
            nxt = WS_IDLE;
        end else if (wr_en) begin
            unique case (st)
                WS_IDLE: if (wr_sop && !wr_eop && !full) nxt = WS_BODY;
                WS_BODY: begin
                    if (wr_eop)    nxt = WS_IDLE;
                    else if (full) nxt = WS_DROP;
                end
                WS_DROP: if (wr_eop) nxt = WS_IDLE;
                default: nxt = WS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_req    = 1'b0;
        patch_req = 1'b0;
        ovf_evt   = 1'b0;
        if (wr_en) begin
            if (!pkt_mode) begin
                if (full) ovf_evt = 1'b1;
                else      wr_req  = 1'b1;
            end else begin
                unique case (st)
                    WS_IDLE: begin
                        if (wr_sop) begin
                            if (full) ovf_evt = 1'b1;
                            else      wr_req  = 1'b1;
                        end
                    end
                    WS_BODY: begin
                        if (full) begin
                            ovf_evt   = 1'b1;
                            patch_req = 1'b1;
                        end else begin
                            wr_req = 1'b1;
                        end
                    end
                    WS_DROP: begin
                        wr_req = 1'b0;
                    end
                    default: begin
                        wr_req = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cpf_sticky.sv
module cpf_sticky #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);

    // Set has priority over clear for the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end

endmodule

// File: rtl/cpkt_fifo.sv
module cpkt_fifo
    import cpf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_mode,
    input  logic              wr_en,
    input  logic [CPF_DW-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [CPF_DW-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              rd_err,
    output logic              full,
    output logic              empty,
    input  logic              clr_ovf,
    input  logic              clr_unf,
    output logic              ovf_flag,
    output logic              unf_flag
);

    localparam int unsigned NFLAG = 2;

    word_t            in_word;
    word_t            out_word;
    logic             wr_req;
    logic             patch_req;
    logic             ovf_evt;
    logic             unf_evt;
    logic [NFLAG-1:0] flags;

    assign in_word = '{sop: wr_sop, eop: wr_eop, err: 1'b0, data: wr_data};
    assign unf_evt = rd_en && empty;

    cpf_wr_fsm u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_mode  (pkt_mode),
        .wr_en     (wr_en),
        .wr_sop    (wr_sop),
        .wr_eop    (wr_eop),
        .full      (full),
        .wr_req    (wr_req),
        .patch_req (patch_req),
        .ovf_evt   (ovf_evt)
    );

    cpf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_word   (in_word),
        .patch_req (patch_req),
        .rd_req    (rd_en),
        .full      (full),
        .empty     (empty),
        .rd_valid  (rd_valid),
        .rd_word   (out_word)
    );

    cpf_sticky #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({ovf_evt, unf_evt}),
        .clr_i ({clr_ovf, clr_unf}),
        .q     (flags)
    );

    assign rd_data  = out_word.data;
    assign rd_sop   = out_word.sop;
    assign rd_eop   = out_word.eop;
    assign rd_err   = out_word.err;
    assign ovf_flag = flags[1];
    assign unf_flag = flags[0];

endmodule

// File: rtl/cpkt_fifo_chk.sv
module cpkt_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic pkt_mode,
    input logic wr_en,
    input logic rd_en,
    input logic rd_valid,
    input logic full,
    input logic empty,
    input logic clr_ovf,
    input logic ovf_flag,
    input logic unf_flag
);

    a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r4_full_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    a_r4_cell_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_mode && wr_en && full) |=> ovf_flag);

    a_r2_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty) |=> rd_valid);

    a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (!rd_valid && unf_flag));

    a_r3_idle_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

endmodule

bind cpkt_fifo cpkt_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_mode (pkt_mode),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .full     (full),
    .empty    (empty),
    .clr_ovf  (clr_ovf),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
);

// File: tb/tb_cpkt_fifo.sv
module tb_cpkt_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_sop = 1'b0;
    logic        wr_eop = 1'b0;
    logic        rd_en = 1'b0;
    logic        clr_ovf = 1'b0;
    logic        clr_unf = 1'b0;
    logic        rd_valid, rd_sop, rd_eop, rd_err, full, empty, ovf_flag, unf_flag;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cpkt_fifo #(.DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err),
        .full(full), .empty(empty), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    // Vector: [20] wr, [19] rd, [18:11] data low byte, [10] exp valid,
    // [9:2] exp data low byte, [1] exp empty, [0] exp full (cell mode)
    localparam logic [20:0] VEC [6] = '{
        {1'b1, 1'b0, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h02, 1'b1, 8'h01, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b1, 8'h02, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b1, 8'h03, 1'b1, 1'b0}
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] d, input logic s, input logic e);
        wr_en = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
        cyc();
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic get(input string req, input logic [31:0] ed, input logic [2:0] etag);
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        chk(req, {31'd0, rd_valid}, 32'd1);
        chk(req, rd_data, ed);
        chk(req, {29'd0, rd_sop, rd_eop, rd_err}, {29'd0, etag});
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 empty", {31'd0, empty}, 32'd1);
        chk("R1 full", {31'd0, full}, 32'd0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 flags", {30'd0, ovf_flag, unf_flag}, 32'd0);

        // Vector table, cell mode (R2, R9)
        for (int k = 0; k < 6; k++) begin
            wr_en   = VEC[k][20];
            rd_en   = VEC[k][19];
            wr_data = 32'hC0DE_0000 | {24'd0, VEC[k][18:11]};
            cyc();
            wr_en = 1'b0;
            rd_en = 1'b0;
            chk("R2 table valid", {31'd0, rd_valid}, {31'd0, VEC[k][10]});
            if (VEC[k][10]) chk("R2 table data", rd_data, 32'hC0DE_0000 | {24'd0, VEC[k][9:2]});
            chk("R9 table empty", {31'd0, empty}, {31'd0, VEC[k][1]});
            chk("R3 table full", {31'd0, full}, {31'd0, VEC[k][0]});
        end
        chk("R9 unf set", {31'd0, unf_flag}, 32'd1);
        chk("R9 ovf clear", {31'd0, ovf_flag}, 32'd0);

        // R10 clear underflow
        clr_unf = 1'b1; cyc(); clr_unf = 1'b0;
        chk("R10 unf cleared", {31'd0, unf_flag}, 32'd0);

        // Cell fill, no start markers (R11, R3, R4)
        for (int i = 0; i < 8; i++) put(32'h1000_0000 + i, 1'b0, 1'b0);
        chk("R11 R3 full after depth", {31'd0, full}, 32'd1);
        put(32'hDEAD_BEEF, 1'b0, 1'b0);
        chk("R4 ovf set", {31'd0, ovf_flag}, 32'd1);
        clr_ovf = 1'b1;
        put(32'hDEAD_0001, 1'b0, 1'b0);
        clr_ovf = 1'b0;
        chk("R10 set wins over clear", {31'd0, ovf_flag}, 32'd1);
        clr_ovf = 1'b1; cyc(); clr_ovf = 1'b0;
        chk("R10 ovf cleared", {31'd0, ovf_flag}, 32'd0);
        chk("R10 unf untouched", {31'd0, unf_flag}, 32'd0);
        for (int i = 0; i < 8; i++) get("R4 R2 cell order", 32'h1000_0000 + i, 3'b000);
        chk("R3 empty after drain", {31'd0, empty}, 32'd1);

        // Packet mode: stray word (R6)
        pkt_mode = 1'b1;
        cyc();
        put(32'h5555_5555, 1'b0, 1'b0);
        chk("R6 stray dropped", {31'd0, empty}, 32'd1);
        chk("R6 no flag", {31'd0, ovf_flag}, 32'd0);

        // Mid-packet overflow and abort (R7, R8)
        put(32'h2000_0000, 1'b1, 1'b0);
        for (int i = 1; i < 8; i++) put(32'h2000_0000 + i, 1'b0, 1'b0);
        chk("R7 full", {31'd0, full}, 32'd1);
        put(32'h2000_0008, 1'b0, 1'b0);
        chk("R7 ovf set", {31'd0, ovf_flag}, 32'd1);
        get("R7 first word", 32'h2000_0000, 3'b100);
        put(32'h2000_0009, 1'b0, 1'b0);
        put(32'h2000_000A, 1'b0, 1'b1);
        put(32'h3000_0000, 1'b1, 1'b1);
        for (int i = 1; i < 7; i++) get("R7 body", 32'h2000_0000 + i, 3'b000);
        get("R7 aborted tail", 32'h2000_0007, 3'b011);
        get("R8 next packet", 32'h3000_0000, 3'b110);
        chk("R8 empty after", {31'd0, empty}, 32'd1);

        // Start and short words meeting full (R5)
        clr_ovf = 1'b1; cyc(); clr_ovf = 1'b0;
        for (int i = 0; i < 8; i++) put(32'h4000_0000 + i, 1'b1, 1'b1);
        put(32'h4000_00FF, 1'b1, 1'b1);
        chk("R5 short ovf", {31'd0, ovf_flag}, 32'd1);
        clr_ovf = 1'b1; cyc(); clr_ovf = 1'b0;
        chk("R5 cleared", {31'd0, ovf_flag}, 32'd0);
        put(32'h4000_00EE, 1'b1, 1'b0);
        chk("R5 sop ovf", {31'd0, ovf_flag}, 32'd1);
        get("R5 first short", 32'h4000_0000, 3'b110);
        put(32'h4000_00DD, 1'b0, 1'b0);
        for (int i = 1; i < 8; i++) get("R5 R6 shorts", 32'h4000_0000 + i, 3'b110);
        chk("R5 R6 empty after", {31'd0, empty}, 32'd1);

        report();
        $finish;
    end

endmodule